// File: doc/BRIEF.md
# Serial Peripheral Memory Slave with Hold and Write Protect

This block is a mode-0 SPI slave that gives a host serial access to a 2048-byte memory kept in flip-flops. The host lowers chip select, shifts in an eight-bit command, and for array accesses a two-byte address. It then streams data bytes in or out. The address advances by one after every byte, so one command can cover any run of bytes, and the run wraps from the top of the array to the bottom.

A small status register holds a write-enable latch and a two-bit protection field. The protection field locks the top quarter, the top half or the whole array against writes. A hold input lets the host pause a transfer in the middle and come back to it later. While paused, the serial output floats and clock and select activity is not seen. A write-protect input blocks changes to the status register, and so to the protection setting.

All SPI pins are brought into the system clock domain through synchronizers. Their edges are detected there, so the SPI clock must be slower than about a quarter of the system clock.

Top module: `spi_fram_slave`

## Requirements
- R1: After reset the status byte reads 0x00, the memory holds zeros and the serial output is not driven.
- R2: SI is taken on the rising edge of SCK and SO changes after the falling edge of SCK. Each byte travels MSB first, and read data becomes valid on the falling edge that follows the last command or address bit.
- R3: A command is decoded only from the first byte after a falling edge of chip select. Any further bytes after a one-byte command (0x06 set write enable, 0x04 clear write enable) are ignored until chip select rises, and SCK activity while chip select is high has no effect.
- R4: so_oe is high only while data from a read (0x03) or status read (0x05) is being shifted out with chip select low and no hold in effect. At all other times SO is high-impedance.
- R5: While hold is in effect, SCK and chip-select transitions are ignored and SO floats. Releasing hold resumes the transfer at the bit where it stopped.
- R6: A change on hold_n takes effect only while SCK is low. A change made while SCK is high waits for SCK to fall.
- R7: The write-enable latch (status bit 1) is set by 0x06 and cleared by 0x04. It is also cleared when chip select rises after a write (0x02) or status write (0x01) that received at least one full data byte.
- R8: A write (0x02) or status write (0x01) issued while the write-enable latch is clear changes nothing.
- R9: The address is two bytes, high byte first. Only the low 11 bits are used and the upper 5 bits are ignored.
- R10: Burst reads and writes advance the address by one per byte and wrap from 0x7FF to 0x000.
- R11: Status byte layout: bit 1 is the write-enable latch, bits 3:2 are the protect field, and all other bits read 0. A status write changes only bits 3:2, and a status read repeats the status byte for as long as clocks continue.
- R12: A status write does not change the protect field while wp_n is low.
- R13: Protect field 0 locks nothing, 1 locks 0x600–0x7FF, 2 locks 0x400–0x7FF and 3 locks the whole array. A data byte aimed at a locked address is dropped, but the address still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | SPI serial clock, mode 0 |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low transfer pause |
| wp_n | input | 1 | Active-low write protect for the status register |
| so | output | 1 | Serial data out, high-impedance when not enabled |
| so_oe | output | 1 | High while so is being driven |

## Verification
The bench checks writes across the 0x7FF wrap and reads them back. A counter that saturated or failed to wrap would put the last bytes at the wrong place. A burst that begins on a locked address and continues into an unlocked one catches a design that stops advancing the address when it drops a byte. The bench also checks the boundaries of each protect setting, both one byte below and at the start of the locked range. A hold is applied mid-byte, with hold_n lowered while SCK is high and with chip select pulsed during the pause. A design that honoured hold at once, counted clocks during the pause or let the pulse restart the frame would return a corrupted byte or drive SO at the wrong time. The bench also sends a second opcode inside one frame and checks status writes with write protect and without write enable. A design that re-decoded the extra byte or ignored either guard would change the status byte.

// File: rtl/spi_fram_pkg.sv
package spi_fram_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [7:0] {
    OP_WRSR  = 8'h01,
    OP_WRITE = 8'h02,
    OP_READ  = 8'h03,
    OP_WRDI  = 8'h04,
    OP_RDSR  = 8'h05,
    OP_WREN  = 8'h06
  } cmd_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_SWRITE,
    PH_SREAD,
    PH_SKIP
  } phase_e;

  // Lock decision from the protect field and the two top address bits.
  function automatic logic is_locked(input logic [1:0] prot, input logic [1:0] top2);
    case (prot)
      2'd0:    is_locked = 1'b0;
      2'd1:    is_locked = &top2;
      2'd2:    is_locked = top2[1];
      default: is_locked = 1'b1;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] status_image(input logic [1:0] prot, input logic wen);
    status_image = {4'b0000, prot, wen, 1'b0};
  endfunction

endpackage

// File: rtl/spi_fram_front.sv
module spi_fram_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic sel,
  output logic hold_act,
  output logic sck_lvl,
  output logic si_lvl,
  output logic wp_lvl,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel_start,
  output logic sel_end
);

  localparam int NSIG = 5;
  // bit order {wp_n, hold_n, si, sck, cs_n}
  localparam logic [NSIG-1:0] IDLE_LVL = 5'b11001;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] chain [SYNC_STAGES];
  logic [NSIG-1:0] synced;
  logic            cs_s, hold_s, sck_prev;

  assign raw = {wp_n, hold_n, si, sck, cs_n};

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= IDLE_LVL;
          else        chain[g] <= raw;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= IDLE_LVL;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign synced  = chain[SYNC_STAGES-1];
  assign cs_s    = synced[0];
  assign sck_lvl = synced[1];
  assign si_lvl  = synced[2];
  assign hold_s  = synced[3];
  assign wp_lvl  = synced[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      hold_act <= 1'b0;
      sel      <= 1'b0;
    end else begin
      sck_prev <= sck_lvl;
      if (!sck_lvl) hold_act <= ~hold_s;
      if (!hold_act) sel <= ~cs_s;
    end
  end

  assign sck_rise  = sel & ~hold_act & sck_lvl & ~sck_prev;
  assign sck_fall  = sel & ~hold_act & ~sck_lvl & sck_prev;
  assign sel_start = ~hold_act & ~cs_s & ~sel;
  assign sel_end   = ~hold_act & cs_s & sel;

endmodule

// File: rtl/spi_fram_array.sv
module spi_fram_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/spi_fram_engine.sv
module spi_fram_engine
  import spi_fram_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sel_start,
  input  logic              sel_end,
  input  logic              si_lvl,
  input  logic              wp_lvl,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              so_d,
  output logic              out_active,
  output logic              wel,
  output logic [1:0]        prot
);

  localparam int AF_W = 2 * BYTE_W;
  localparam int BC_W = $clog2(BYTE_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(BYTE_W - 1);

  phase_e            ph;
  logic [BYTE_W-1:0] cmd, shin, ahi, osh;
  logic [BC_W-1:0]   ibit, obit;
  logic [ADDR_W-1:0] addr;
  logic              abyte, load_pend, wr_done;

  logic [BYTE_W-1:0] in_byte;
  logic              byte_done;
  logic [AF_W-1:0]   addr_field;
  logic [ADDR_W-1:0] rx_addr;
  logic              locked;
  logic              shifting_in, shifting_out;

  assign in_byte      = {shin[BYTE_W-2:0], si_lvl};
  assign shifting_in  = (ph != PH_IDLE) && (ph != PH_SKIP);
  assign byte_done    = sck_rise && shifting_in && (ibit == LAST_BIT);
  assign addr_field   = {ahi, in_byte};
  assign rx_addr      = addr_field[ADDR_W-1:0];
  assign locked       = is_locked(prot, addr[ADDR_W-1 -: 2]);
  assign shifting_out = (ph == PH_RDATA) || (ph == PH_SREAD);

  assign mem_we    = (ph == PH_WDATA) && byte_done && !locked;
  assign mem_waddr = addr;
  assign mem_wdata = in_byte;
  assign mem_raddr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= PH_IDLE;
      cmd        <= '0;
      shin       <= '0;
      ahi        <= '0;
      osh        <= '0;
      ibit       <= '0;
      obit       <= '0;
      addr       <= '0;
      abyte      <= 1'b0;
      load_pend  <= 1'b0;
      wr_done    <= 1'b0;
      so_d       <= 1'b0;
      out_active <= 1'b0;
      wel        <= 1'b0;
      prot       <= 2'd0;
    end else begin
      if (load_pend) begin
        osh       <= mem_rdata;
        load_pend <= 1'b0;
      end
      if (sel_start) begin
        ph         <= PH_CMD;
        ibit       <= '0;
        obit       <= '0;
        abyte      <= 1'b0;
        wr_done    <= 1'b0;
        out_active <= 1'b0;
      end else if (sel_end) begin
        ph         <= PH_IDLE;
        out_active <= 1'b0;
        if (wr_done) wel <= 1'b0;
      end else begin
        if (sck_rise && shifting_in) begin
          shin <= in_byte;
          ibit <= ibit + 1'b1;
        end
        if (byte_done) begin
          case (ph)
            PH_CMD: begin
              cmd <= in_byte;
              case (in_byte)
                OP_WREN:  begin wel <= 1'b1; ph <= PH_SKIP; end
                OP_WRDI:  begin wel <= 1'b0; ph <= PH_SKIP; end
                OP_RDSR:  begin osh <= status_image(prot, wel); ph <= PH_SREAD; end
                OP_WRSR:  ph <= wel ? PH_SWRITE : PH_SKIP;
                OP_READ:  ph <= PH_ADDR;
                OP_WRITE: ph <= wel ? PH_ADDR : PH_SKIP;
                default:  ph <= PH_SKIP;
              endcase
            end
            PH_ADDR: begin
              if (!abyte) begin
                ahi   <= in_byte;
                abyte <= 1'b1;
              end else begin
                addr <= rx_addr;
                if (cmd == OP_READ) begin
                  ph        <= PH_RDATA;
                  load_pend <= 1'b1;
                end else begin
                  ph <= PH_WDATA;
                end
              end
            end
            PH_WDATA: begin
              addr    <= addr + 1'b1;
              wr_done <= 1'b1;
            end
            PH_SWRITE: begin
              if (wp_lvl) prot <= in_byte[3:2];
              wr_done <= 1'b1;
              ph      <= PH_SKIP;
            end
            default: ;
          endcase
        end
        if (sck_fall && shifting_out) begin
          so_d       <= osh[BYTE_W-1];
          out_active <= 1'b1;
          osh        <= {osh[BYTE_W-2:0], 1'b0};
          obit       <= obit + 1'b1;
          if (obit == LAST_BIT) begin
            if (ph == PH_RDATA) begin
              addr      <= addr + 1'b1;
              load_pend <= 1'b1;
            end else begin
              osh <= status_image(prot, wel);
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_fram_slave.sv
module spi_fram_slave
  import spi_fram_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);

  logic              sel, hold_act, sck_lvl, si_lvl, wp_lvl;
  logic              sck_rise, sck_fall, sel_start, sel_end;
  logic              mem_we, so_d, out_active, wel;
  logic [1:0]        prot;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [BYTE_W-1:0] mem_wdata, mem_rdata;

  spi_fram_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sck       (sck),
    .si        (si),
    .hold_n    (hold_n),
    .wp_n      (wp_n),
    .sel       (sel),
    .hold_act  (hold_act),
    .sck_lvl   (sck_lvl),
    .si_lvl    (si_lvl),
    .wp_lvl    (wp_lvl),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .sel_start (sel_start),
    .sel_end   (sel_end)
  );

  spi_fram_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .sel_start  (sel_start),
    .sel_end    (sel_end),
    .si_lvl     (si_lvl),
    .wp_lvl     (wp_lvl),
    .mem_rdata  (mem_rdata),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .mem_raddr  (mem_raddr),
    .so_d       (so_d),
    .out_active (out_active),
    .wel        (wel),
    .prot       (prot)
  );

  spi_fram_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  assign so_oe = out_active & sel & ~hold_act;
  assign so    = so_oe ? so_d : 1'bz;

endmodule

// File: rtl/spi_fram_slave_chk.sv
module spi_fram_slave_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              hold_act,
  input logic              sck_lvl,
  input logic              sck_rise,
  input logic              sck_fall,
  input logic              so_oe,
  input logic              wel,
  input logic [1:0]        prot,
  input logic              wp_lvl,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr
);

  assert_oe_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (sel && !hold_act));

  assert_hold_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act |-> (!sck_rise && !sck_fall));

  assert_hold_sck_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act != $past(hold_act)) |-> !$past(sck_lvl));

  assert_wel_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(sck_rise));

  assert_write_needs_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wel);

  assert_prot_needs_wp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (prot != $past(prot)) |-> $past(wp_lvl));

  assert_all_locked_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (prot == 2'd3) |-> !mem_we);

  assert_upper_half_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && prot == 2'd2) |-> !mem_waddr[ADDR_W-1]);

endmodule

bind spi_fram_slave spi_fram_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel       (sel),
  .hold_act  (hold_act),
  .sck_lvl   (sck_lvl),
  .sck_rise  (sck_rise),
  .sck_fall  (sck_fall),
  .so_oe     (so_oe),
  .wel       (wel),
  .prot      (prot),
  .wp_lvl    (wp_lvl),
  .mem_we    (mem_we),
  .mem_waddr (mem_waddr)
);

// File: tb/test_spi_fram_slave.sv
`timescale 1ns/1ps
module test_spi_fram_slave;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  wire  so;
  wire  so_oe;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_fram_slave i_spi_fram_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe)
  );

  // {16-bit address field, data}
  localparam logic [23:0] VEC [8] = '{
    {16'h0000, 8'h11}, {16'h0123, 8'h5A}, {16'h02AA, 8'hC3}, {16'h03FF, 8'h80},
    {16'h0400, 8'h01}, {16'h05FF, 8'hFE}, {16'h07FF, 8'hA5}, {16'hF805, 8'h3C}
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic bit_x(input logic din, output logic dout);
    si = din;
    half();
    dout = so_oe ? so : 1'b0;
    sck = 1'b1;
    half();
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) bit_x(tx[i], rx[i]);
  endtask

  task automatic sel_lo();
    half(); cs_n = 1'b0; half();
  endtask

  task automatic sel_hi();
    half(); cs_n = 1'b1; half(); half();
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    sel_lo(); xfer(op, d); sel_hi();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    sel_lo(); xfer(8'h05, d); xfer(8'h00, s); sel_hi();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    sel_lo(); xfer(8'h01, d); xfer(v, d); sel_hi();
  endtask

  task automatic write1(input logic [15:0] a, input logic [7:0] v);
    logic [7:0] d;
    sel_lo(); xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d); xfer(v, d); sel_hi();
  endtask

  task automatic read1(input logic [15:0] a, output logic [7:0] v);
    logic [7:0] d;
    sel_lo(); xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d); xfer(8'h00, v); sel_hi();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, v, d, b0, b1, b2, b3;
    logic [7:0] hb;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check8("R1 so_oe after reset", {7'd0, so_oe}, 8'h00);
    rdsr(s);   check8("R1 status after reset", s, 8'h00);
    read1(16'h0123, v); check8("R1 memory zero after reset", v, 8'h00);

    // R8 write without enable
    write1(16'h0020, 8'h99);
    read1(16'h0020, v); check8("R8 write without latch", v, 8'h00);
    wrsr(8'h0C);
    rdsr(s); check8("R8 status write without latch", s, 8'h00);

    // R7 / R11 latch control and repeated status
    cmd1(8'h06);
    sel_lo(); xfer(8'h05, d); xfer(8'h00, b0); xfer(8'h00, b1); sel_hi();
    check8("R7 latch set", b0, 8'h02);
    check8("R11 status repeats", b1, 8'h02);
    cmd1(8'h04);
    rdsr(s); check8("R7 latch cleared by 0x04", s, 8'h00);

    // R3 extra byte after one-byte command is ignored
    sel_lo(); xfer(8'h06, d);
    check8("R4 so_oe low in command frame", {7'd0, so_oe}, 8'h00);
    xfer(8'h04, d); sel_hi();
    rdsr(s); check8("R3 second opcode in frame ignored", s, 8'h02);
    cmd1(8'h04);

    // R3 SCK toggling while deselected
    for (int i = 0; i < 8; i++) bit_x(1'b1, d[0]);
    rdsr(s); check8("R3 clocks while deselected ignored", s, 8'h00);

    // Vector table: write then read back, upper address bits ignored (R9)
    for (int i = 0; i < 8; i++) begin
      cmd1(8'h06);
      write1(VEC[i][23:8], VEC[i][7:0]);
    end
    rdsr(s); check8("R7 latch cleared after write", s, 8'h00);
    for (int i = 0; i < 8; i++) begin
      read1(VEC[i][23:8] ^ 16'hA800, v);
      check8($sformatf("R9 R2 vector %0d", i), v, VEC[i][7:0]);
    end
    read1(16'h0005, v); check8("R9 upper bits dropped on write", v, 8'h3C);

    // R10 wrap burst
    cmd1(8'h06);
    sel_lo(); xfer(8'h02, d); xfer(8'h07, d); xfer(8'hFE, d);
    xfer(8'hD0, d); xfer(8'hD1, d); xfer(8'hD2, d); xfer(8'hD3, d); sel_hi();
    sel_lo(); xfer(8'h03, d); xfer(8'h07, d); xfer(8'hFE, d);
    xfer(8'h00, b0);
    check8("R4 so_oe high during read", {7'd0, so_oe}, 8'h01);
    xfer(8'h00, b1); xfer(8'h00, b2); xfer(8'h00, b3); sel_hi();
    check8("R4 so_oe low after deselect", {7'd0, so_oe}, 8'h00);
    check8("R10 burst byte 0x7FE", b0, 8'hD0);
    check8("R10 burst byte 0x7FF", b1, 8'hD1);
    check8("R10 burst wrapped 0x000", b2, 8'hD2);
    check8("R10 burst wrapped 0x001", b3, 8'hD3);

    // R5 / R6 hold in the middle of a read of 0x0123 (0x5A)
    sel_lo(); xfer(8'h03, d); xfer(8'h01, d); xfer(8'h23, d);
    for (int i = 7; i >= 5; i--) bit_x(1'b0, hb[i]);
    si = 1'b0; half(); hb[4] = so_oe ? so : 1'b0;
    sck = 1'b1;
    hold_n = 1'b0;
    repeat (6) @(negedge clk);
    check8("R6 hold not honoured while SCK high", {7'd0, so_oe}, 8'h01);
    half(); sck = 1'b0; half();
    check8("R5 output floats during hold", {7'd0, so_oe}, 8'h00);
    for (int i = 0; i < 3; i++) begin sck = 1'b1; half(); sck = 1'b0; half(); end
    cs_n = 1'b1; half(); cs_n = 1'b0; half();
    hold_n = 1'b1; half();
    for (int i = 3; i >= 0; i--) bit_x(1'b0, hb[i]);
    sel_hi();
    check8("R5 byte intact across hold", hb, 8'h5A);

    // R13 protect field 1: upper quarter
    cmd1(8'h06); wrsr(8'h04);
    rdsr(s); check8("R11 status after protect write", s, 8'h04);
    cmd1(8'h06);
    sel_lo(); xfer(8'h02, d); xfer(8'h05, d); xfer(8'hFE, d);
    xfer(8'h66, d); xfer(8'h77, d); xfer(8'h88, d); sel_hi();
    read1(16'h05FE, v); check8("R13 quarter: 0x5FE writable", v, 8'h66);
    read1(16'h05FF, v); check8("R13 quarter: 0x5FF writable", v, 8'h77);
    read1(16'h0600, v); check8("R13 quarter: 0x600 locked", v, 8'h00);
    cmd1(8'h06);
    sel_lo(); xfer(8'h02, d); xfer(8'h07, d); xfer(8'hFF, d);
    xfer(8'hAA, d); xfer(8'hBB, d); sel_hi();
    read1(16'h07FF, v); check8("R13 locked byte dropped", v, 8'hD1);
    read1(16'h0000, v); check8("R13 address advances past dropped byte", v, 8'hBB);

    // R13 protect field 2: upper half
    cmd1(8'h06); wrsr(8'h08);
    cmd1(8'h06);
    sel_lo(); xfer(8'h02, d); xfer(8'h03, d); xfer(8'hFF, d);
    xfer(8'h12, d); xfer(8'h34, d); sel_hi();
    read1(16'h03FF, v); check8("R13 half: 0x3FF writable", v, 8'h12);
    read1(16'h0400, v); check8("R13 half: 0x400 locked", v, 8'h01);

    // R13 protect field 3: all
    cmd1(8'h06); wrsr(8'h0C);
    cmd1(8'h06); write1(16'h0010, 8'h55);
    read1(16'h0010, v); check8("R13 all locked", v, 8'h00);

    // R12 write protect pin blocks status write
    wp_n = 1'b0; half();
    cmd1(8'h06); wrsr(8'h00);
    rdsr(s); check8("R12 protect field kept with wp_n low", s, 8'h0C);
    wp_n = 1'b1; half();

    // R11 only bits 3:2 writable
    cmd1(8'h06); wrsr(8'hF3);
    rdsr(s); check8("R11 only protect bits written", s, 8'h00);
    cmd1(8'h06); write1(16'h0010, 8'h55);
    read1(16'h0010, v); check8("R13 unlocked again", v, 8'h55);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule